// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a W-bit storage register, four bits wide by default, whose contents can be kept, moved one place towards either end, or replaced by a parallel word. A two-bit mode input chooses the operation. A synchronous clear input forces the register to zero and takes priority over every mode.

Each end has its own serial input, which feeds the cell that is vacated by a shift, and its own serial output. The leftmost cell is bit W-1 and the rightmost cell is bit 0. All cells take their new values together on the rising clock edge, so a shift moves data by exactly one position per cycle. The block suits parallel-to-serial and serial-to-parallel conversion in either direction, and small sample windows.

Top module: `ushr_top`

## Requirements
- R1: When clear is low and mode equals 2'b00, the contents after the clock edge equal the contents before it, whatever the serial and parallel inputs are.
- R2: When clear is low and mode equals 2'b01 (right shift), each bit i below W-1 takes the old bit i+1, and bit W-1 takes the left serial input.
- R3: When clear is low and mode equals 2'b10 (left shift), each bit i above 0 takes the old bit i-1, and bit 0 takes the right serial input.
- R4: When clear is low and mode equals 2'b11, the register takes the parallel input word.
- R5: When clear is high at a rising edge, the register becomes all zeros after that edge, for every mode value, including load.
- R6: A shift moves data by exactly one position per clock edge. A value in one cell never reaches a cell two places away in a single cycle.
- R7: The left serial output always equals register bit W-1, and the right serial output always equals register bit 0. Both are taken from the registered contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, overrides mode |
| mode | input | 2 | 00 hold, 01 right shift, 10 left shift, 11 load |
| ser_left_i | input | 1 | Serial bit entering bit W-1 on a right shift |
| ser_right_i | input | 1 | Serial bit entering bit 0 on a left shift |
| par_i | input | W | Parallel load word |
| q_o | output | W | Register contents |
| ser_left_o | output | 1 | Bit W-1 of the contents |
| ser_right_o | output | 1 | Bit 0 of the contents |

## Verification
Every operation, clear included, shows its result exactly one edge after the inputs are applied, because there is a single register stage between the inputs and the outputs. The serial outputs follow the contents with no extra delay. The driver applies the inputs at the falling edge and pushes the model's next contents into a queue. The monitor pops one item just after each rising edge and compares it with q_o and both serial outputs. This keeps each check on the one cycle in which its result becomes due.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHR   = 2'b01,
        MODE_SHL   = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    typedef struct packed {
        logic  clear;
        mode_e mode;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic clr, input logic [1:0] mode);
        ctl_t c;
        c.clear = clr;
        c.mode  = mode_e'(mode);
        return c;
    endfunction

endpackage

// File: rtl/ushr_ctrl.sv
module ushr_ctrl
    import ushr_pkg::*;
(
    input  logic       clr,
    input  logic [1:0] mode,
    output ctl_t       ctl
);
    always_comb begin
        ctl = decode_ctl(clr, mode);
    end
endmodule

// File: rtl/ushr_cell.sv
module ushr_cell
    import ushr_pkg::*;
(
    input  logic clk,
    input  ctl_t ctl,
    input  logic from_left,
    input  logic from_right,
    input  logic par_bit,
    output logic q
);
    logic nxt;

    always_comb begin
        unique case (ctl.mode)
            MODE_HOLD: nxt = q;
            MODE_SHR:  nxt = from_left;
            MODE_SHL:  nxt = from_right;
            MODE_LOAD: nxt = par_bit;
            default:   nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (ctl.clear) q <= 1'b0;
        else           q <= nxt;
    end
endmodule

// File: rtl/ushr_top.sv
module ushr_top
    import ushr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [1:0]   mode,
    input  logic         ser_left_i,
    input  logic         ser_right_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] q_o,
    output logic         ser_left_o,
    output logic         ser_right_o
);
    localparam int MSB = W - 1;

    ctl_t         ctl;
    logic [W-1:0] cells;

    ushr_ctrl u_ctrl (
        .clr  (clr),
        .mode (mode),
        .ctl  (ctl)
    );

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic lft;
        logic rgt;
        if (i == MSB) begin : g_lend
            assign lft = ser_left_i;
        end else begin : g_lmid
            assign lft = cells[i+1];
        end
        if (i == 0) begin : g_rend
            assign rgt = ser_right_i;
        end else begin : g_rmid
            assign rgt = cells[i-1];
        end
        ushr_cell u_cell (
            .clk        (clk),
            .ctl        (ctl),
            .from_left  (lft),
            .from_right (rgt),
            .par_bit    (par_i[i]),
            .q          (cells[i])
        );
    end

    assign q_o         = cells;
    assign ser_left_o  = cells[MSB];
    assign ser_right_o = cells[0];
endmodule

// File: rtl/ushr_chk.sv
module ushr_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr,
    input logic [1:0]   mode,
    input logic         sli,
    input logic         sri,
    input logic [W-1:0] par,
    input logic [W-1:0] q,
    input logic         slo,
    input logic         sro
);
    logic started = 1'b0;
    logic prev_clr = 1'b0;

    always_ff @(posedge clk) begin
        started  <= started | clr;
        prev_clr <= clr;
    end

    // R5: one edge after clear, contents are zero
    always @(posedge clk) begin
        if (prev_clr) begin
            p_clear_zero_r5: assert (q == '0);
        end
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (clr)
        started && mode == 2'b00 |=> $stable(q));

    p_shr_r2: assert property (@(posedge clk) disable iff (clr)
        started && mode == 2'b01 |=> q == {$past(sli), $past(q[W-1:1])});

    p_shl_r3: assert property (@(posedge clk) disable iff (clr)
        started && mode == 2'b10 |=> q == {$past(q[W-2:0]), $past(sri)});

    p_load_r4: assert property (@(posedge clk) disable iff (clr)
        started && mode == 2'b11 |=> q == $past(par));

    p_one_step_r6: assert property (@(posedge clk) disable iff (clr)
        started && mode == 2'b01 |=> q[W-2:0] == $past(q[W-1:1]));

    p_serial_ends_r7: assert property (@(posedge clk) disable iff (clr)
        started |-> (slo == q[W-1]) && (sro == q[0]));
endmodule

bind ushr_top ushr_chk #(.W(W)) u_chk (
    .clk (clk),
    .clr (clr),
    .mode(mode),
    .sli (ser_left_i),
    .sri (ser_right_i),
    .par (par_i),
    .q   (q_o),
    .slo (ser_left_o),
    .sro (ser_right_o)
);

// File: tb/tb_ushr_top.sv
module tb_ushr_top;
    localparam int W = 4;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         ser_left_i = 1'b0;
    logic         ser_right_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic [W-1:0] q_o;
    logic         ser_left_o;
    logic         ser_right_o;

    item_t        sb[$];
    logic [W-1:0] mdl = '0;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    ushr_top #(.W(W)) dut (
        .clk         (clk),
        .clr         (clr),
        .mode        (mode),
        .ser_left_i  (ser_left_i),
        .ser_right_i (ser_right_i),
        .par_i       (par_i),
        .q_o         (q_o),
        .ser_left_o  (ser_left_o),
        .ser_right_o (ser_right_o)
    );

    task automatic drive(input logic c, input logic [1:0] m, input logic sl,
                         input logic sr, input logic [W-1:0] p, input string tag);
        item_t it;
        @(negedge clk);
        clr = c; mode = m; ser_left_i = sl; ser_right_i = sr; par_i = p;
        if (c)              mdl = '0;
        else if (m == 2'b01) mdl = {sl, mdl[W-1:1]};
        else if (m == 2'b10) mdl = {mdl[W-2:0], sr};
        else if (m == 2'b11) mdl = p;
        it.exp = mdl;
        it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_chk++;
                if (q_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: q_o=%b expected %b", it.tag, q_o, it.exp);
                end
                n_chk++;
                if (ser_left_o !== it.exp[W-1] || ser_right_o !== it.exp[0]) begin
                    n_fail++;
                    $display("FAIL R7: serial outs=%b%b expected %b%b",
                             ser_left_o, ser_right_o, it.exp[W-1], it.exp[0]);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        drive(1, 2'b11, 1, 1, 4'b1111, "R5 reset with load mode");
        drive(0, 2'b11, 0, 0, 4'b1010, "R4 load 1010");
        drive(0, 2'b00, 1, 1, 4'b0101, "R1 hold, inputs toggled");
        drive(0, 2'b00, 0, 1, 4'b1111, "R1 hold again");
        drive(0, 2'b01, 1, 0, 4'b0000, "R2 shift right sl=1");
        drive(0, 2'b01, 0, 1, 4'b0000, "R2 shift right sl=0");
        drive(0, 2'b10, 0, 1, 4'b0000, "R3 shift left sr=1");
        drive(0, 2'b10, 1, 0, 4'b0000, "R3 shift left sr=0");
        drive(0, 2'b11, 0, 0, 4'b1001, "R4 load 1001");
        drive(1, 2'b01, 1, 1, 4'b1111, "R5 clear over shift right");
        drive(0, 2'b11, 0, 0, 4'b1000, "R4 load 1000");
        for (int k = 0; k < W; k++) drive(0, 2'b01, 0, 0, 4'b0000, "R6 single step right");
        drive(0, 2'b10, 0, 1, 4'b0000, "R6 single step left");
        for (int k = 0; k < W; k++) drive(0, 2'b10, 0, 1, 4'b0000, "R3 fill ones from right");
        drive(1, 2'b10, 0, 1, 4'b0000, "R5 clear over shift left");
        drive(0, 2'b00, 1, 1, 4'b1111, "R1 hold zero");
        drive(0, 2'b11, 0, 0, 4'b0110, "R4 load 0110");
        drive(1, 2'b00, 0, 0, 4'b0000, "R5 clear over hold");
        drive(0, 2'b01, 1, 0, 4'b0000, "R2 shift one into msb");
        drive(0, 2'b01, 1, 0, 4'b0000, "R2 shift second one");
        drive(0, 2'b00, 0, 0, 4'b0000, "R1 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule